// File: doc/BRIEF.md
# Elapsed-Time Counter with Compare Alarm

This block keeps a 48-bit running count that advances by one on every cycle in which the tick enable is high. In a system the tick enable pulses at 32768 Hz, which makes count bit 15 the one-second bit: whole seconds sit in bits 47:15 and bits 14:0 are the sub-second fraction. The count and a 48-bit compare value are each seen on a small synchronous 16-bit register port as three halfword registers, low to high.

When the running count equals a non-zero compare value, a sticky alarm flag is set in a status register. Software acknowledges the flag by writing a 1 to it. An interrupt output is the flag gated by a separate enable input. Reads are not latched across halfwords, so software reading a moving count reads all three halfwords twice and accepts the value only when both passes agree.

Top module: `elapsed_alarm_timer`

## Requirements
- R1: After reset the count, the compare value and the alarm flag are all zero, and `irq_o` is low.
- R2: In a cycle with `tick_en` high and no write to a count halfword, the count increases by one across all 48 bits with carry between halfwords, wrapping from all ones to zero.
- R3: With `tick_en` low and no write to a count halfword, the count holds its value.
- R4: The count halfwords sit at byte offsets 0x00 (bits 15:0), 0x02 (bits 31:16) and 0x04 (bits 47:32). A write replaces only the addressed halfword, the other two keep their value, and no increment happens in that cycle; counting resumes from the new value on the next tick.
- R5: The compare value uses the same layout at offsets 0x08 (bits 15:0), 0x0A (bits 31:16) and 0x0C (bits 47:32), and reads back what was written.
- R6: The alarm flag is bit 0 of the status register at offset 0x1E. On a clock edge where the count already equals a non-zero compare value, the flag becomes 1 and stays 1 until acknowledged.
- R7: Writing offset 0x1E with bit 0 set clears the flag; writing it with bit 0 clear leaves it unchanged. If a match and a clearing write fall on the same edge, the flag stays set.
- R8: A compare value of zero is the disabled setting: it never sets the flag, even while the count is zero.
- R9: `irq_o` is high exactly when the alarm flag is set and `irq_en` is high.
- R10: Reads of any other offset, including odd offsets, return zero and writes to them change no state; bits 15:1 of the status register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count advance enable, one pulse per count step |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_en | input | 1 | Interrupt enable |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The bench drives the count to all ones and ticks it, catching a counter that drops the carry between halfwords or fails to wrap to zero. It writes single halfwords with the tick high, which exposes a design that also increments in a load cycle or disturbs the neighbouring halfwords. It lines up a match with an acknowledge on the same edge, where a design giving clear priority would lose the alarm, and parks a zero count against a zero compare value, where a design without the disabled setting would raise a spurious alarm right after reset. Random ticks and writes, including unmapped and odd offsets, are checked against a bench model of every register.

// File: rtl/etm_pkg.sv
package etm_pkg;
  localparam int unsigned CNT_BITS  = 48;
  localparam int unsigned HALF_BITS = 16;
  localparam int unsigned ADDR_BITS = 5;
  localparam int unsigned CNT_OFS   = 'h00;
  localparam int unsigned CMP_OFS   = 'h08;
  localparam int unsigned STAT_OFS  = 'h1E;
endpackage

// File: rtl/etm_halfreg.sv
module etm_halfreg #(
  parameter int unsigned W  = etm_pkg::CNT_BITS,
  parameter int unsigned HW = etm_pkg::HALF_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc_en,
  input  logic [W/HW-1:0] hw_we,
  input  logic [HW-1:0]   wdata,
  output logic [W-1:0]    q
);
  localparam int unsigned N = W / HW;

  logic [W-1:0] q_r;
  logic [W-1:0] q_inc;
  logic [W-1:0] q_d;
  logic         any_we;
  logic         load_en;

  assign q_inc   = q_r + W'(1);
  assign any_we  = |hw_we;
  assign load_en = any_we | inc_en;

  // a load of any halfword freezes the whole word for that cycle
  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_half
      assign q_d[gi*HW +: HW] = hw_we[gi] ? wdata :
                                any_we    ? q_r[gi*HW +: HW] :
                                            q_inc[gi*HW +: HW];

      a_r4_half_load: assert property (@(posedge clk) disable iff (!rst_n)
        hw_we[gi] |=> q_r[gi*HW +: HW] == $past(wdata));
      a_r4_half_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (any_we && !hw_we[gi]) |=> $stable(q_r[gi*HW +: HW]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_r <= '0;
    else if (load_en)
      q_r <= q_d;
  end

  assign q = q_r;

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !any_we) |=> q_r == $past(q_r) + W'(1));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !any_we) |=> $stable(q_r));
endmodule

// File: rtl/etm_decode.sv
module etm_decode #(
  parameter int unsigned W  = etm_pkg::CNT_BITS,
  parameter int unsigned HW = etm_pkg::HALF_BITS,
  parameter int unsigned AW = etm_pkg::ADDR_BITS
) (
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [W-1:0]    cnt,
  input  logic [W-1:0]    cmp,
  input  logic            flag,
  output logic [W/HW-1:0] cnt_we,
  output logic [W/HW-1:0] cmp_we,
  output logic            stat_we,
  output logic [HW-1:0]   rdata
);
  localparam int unsigned N    = W / HW;
  localparam int unsigned STEP = HW / 8;

  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_sel
      assign cnt_we[gi] = wr && (addr == AW'(etm_pkg::CNT_OFS + STEP*gi));
      assign cmp_we[gi] = wr && (addr == AW'(etm_pkg::CMP_OFS + STEP*gi));
    end
  endgenerate

  assign stat_we = wr && (addr == AW'(etm_pkg::STAT_OFS));

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (addr == AW'(etm_pkg::CNT_OFS + STEP*i)) rdata = cnt[i*HW +: HW];
      if (addr == AW'(etm_pkg::CMP_OFS + STEP*i)) rdata = cmp[i*HW +: HW];
    end
    if (addr == AW'(etm_pkg::STAT_OFS)) rdata = {{(HW-1){1'b0}}, flag};
  end
endmodule

// File: rtl/etm_alarm.sv
module etm_alarm #(
  parameter int unsigned W = etm_pkg::CNT_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         ack_we,
  input  logic         ack_bit,
  input  logic         irq_en,
  output logic         flag,
  output logic         irq_o
);
  logic match;
  logic ack;
  logic flag_q;
  logic flag_d;
  logic flag_en;

  assign match   = (cnt == cmp) && (|cmp);
  assign ack     = ack_we && ack_bit;
  assign flag_d  = match | (flag_q & ~ack);
  assign flag_en = match | ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (flag_en)
      flag_q <= flag_d;
  end

  assign flag  = flag_q;
  assign irq_o = flag_q & irq_en;

  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == cmp && cmp != '0) |=> flag_q);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(ack_we && ack_bit)) |=> flag_q);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && ack_bit && cnt != cmp) |=> !flag_q);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp == '0 && !flag_q) |=> !flag_q);
  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_o);
endmodule

// File: rtl/elapsed_alarm_timer.sv
module elapsed_alarm_timer #(
  parameter int unsigned CNT_W  = etm_pkg::CNT_BITS,
  parameter int unsigned HALF_W = etm_pkg::HALF_BITS,
  parameter int unsigned ADDR_W = etm_pkg::ADDR_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  input  logic              irq_en,
  output logic              irq_o
);
  localparam int unsigned N = CNT_W / HALF_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic [N-1:0]     cnt_we;
  logic [N-1:0]     cmp_we;
  logic             stat_we;
  logic             flag;

  etm_decode #(.W(CNT_W), .HW(HALF_W), .AW(ADDR_W)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .cnt(cnt), .cmp(cmp), .flag(flag),
    .cnt_we(cnt_we), .cmp_we(cmp_we), .stat_we(stat_we), .rdata(bus_rdata)
  );

  etm_halfreg #(.W(CNT_W), .HW(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_en(tick_en), .hw_we(cnt_we),
    .wdata(bus_wdata), .q(cnt)
  );

  etm_halfreg #(.W(CNT_W), .HW(HALF_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .inc_en(1'b0), .hw_we(cmp_we),
    .wdata(bus_wdata), .q(cmp)
  );

  etm_alarm #(.W(CNT_W)) u_alm (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(cmp), .ack_we(stat_we),
    .ack_bit(bus_wdata[0]), .irq_en(irq_en), .flag(flag), .irq_o(irq_o)
  );

  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_we, cmp_we, stat_we}));
  a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> ({cnt_we, cmp_we, stat_we} == '0));
endmodule

// File: tb/sim_elapsed_alarm_timer.sv
`timescale 1ns/1ps
module sim_elapsed_alarm_timer;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_en;
  logic        irq_o;

  int total;
  int bad;
  bit done;

  logic [47:0] m_cnt;
  logic [47:0] m_cmp;
  logic        m_st;

  elapsed_alarm_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_en(irq_en), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    case (a)
      5'h00: return m_cnt[15:0];
      5'h02: return m_cnt[31:16];
      5'h04: return m_cnt[47:32];
      5'h08: return m_cmp[15:0];
      5'h0A: return m_cmp[31:16];
      5'h0C: return m_cmp[47:32];
      5'h1E: return {15'b0, m_st};
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one modelled clock cycle; a non-empty tag checks bus_rdata before the edge
  task automatic cyc(input bit tk, input bit wr, input logic [4:0] a,
                     input logic [15:0] wd, input string tag);
    bit match;
    @(negedge clk);
    tick_en = tk; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    #2;
    if (tag != "") check(tag, {32'h0, bus_rdata}, {32'h0, exp_rd(a)});
    @(posedge clk);
    match = (m_cnt == m_cmp) && (m_cmp != 48'h0);
    m_st = match | (m_st & ~(wr && a == 5'h1E && wd[0]));
    if (wr && a == 5'h00)      m_cnt[15:0]  = wd;
    else if (wr && a == 5'h02) m_cnt[31:16] = wd;
    else if (wr && a == 5'h04) m_cnt[47:32] = wd;
    else if (tk)               m_cnt = m_cnt + 48'h1;
    if (wr && a == 5'h08) m_cmp[15:0]  = wd;
    if (wr && a == 5'h0A) m_cmp[31:16] = wd;
    if (wr && a == 5'h0C) m_cmp[47:32] = wd;
    #1;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d, input bit tk);
    cyc(tk, 1'b1, a, d, "");
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    cyc(1'b0, 1'b0, a, 16'h0, tag);
  endtask

  task automatic rd_all(input string tag);
    rd(5'h00, tag); rd(5'h02, tag); rd(5'h04, tag);
    rd(5'h08, tag); rd(5'h0A, tag); rd(5'h0C, tag); rd(5'h1E, tag);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0;
    m_cnt = '0; m_cmp = '0; m_st = 1'b0;
    rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; irq_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1 check("R1 irq", {47'h0, irq_o}, 48'h0);
    rd_all("R1");

    // R2 counting, R3 hold
    repeat (5) cyc(1'b1, 1'b0, 5'h00, 16'h0, "");
    rd(5'h00, "R2");
    check("R2 low", m_cnt, 48'h5);
    repeat (4) cyc(1'b0, 1'b0, 5'h00, 16'h0, "R3");

    // R2 wrap and carry, with writes during tick (R4)
    wr_reg(5'h00, 16'hFFFF, 1'b1);
    wr_reg(5'h02, 16'hFFFF, 1'b1);
    wr_reg(5'h04, 16'hFFFF, 1'b1);
    rd_all("R4");
    cyc(1'b1, 1'b0, 5'h00, 16'h0, "");
    check("R2 wrap", m_cnt, 48'h0);
    rd_all("R2");
    wr_reg(5'h00, 16'hFFFF, 1'b0);
    cyc(1'b1, 1'b0, 5'h00, 16'h0, "");
    rd(5'h02, "R2");
    rd(5'h00, "R2");

    // R4 single halfword replaced
    wr_reg(5'h02, 16'h1234, 1'b1);
    rd_all("R4");
    cyc(1'b1, 1'b0, 5'h00, 16'h0, "R4");
    rd(5'h00, "R4");

    // R5 compare readback
    wr_reg(5'h08, 16'hA5A5, 1'b0);
    wr_reg(5'h0A, 16'h5A5A, 1'b0);
    wr_reg(5'h0C, 16'h0F0F, 1'b0);
    rd(5'h08, "R5"); rd(5'h0A, "R5"); rd(5'h0C, "R5");

    // R6 alarm
    wr_reg(5'h00, 16'h0000, 1'b0);
    wr_reg(5'h02, 16'h0000, 1'b0);
    wr_reg(5'h04, 16'h0000, 1'b0);
    wr_reg(5'h08, 16'h0010, 1'b0);
    wr_reg(5'h0A, 16'h0000, 1'b0);
    wr_reg(5'h0C, 16'h0000, 1'b0);
    rd(5'h1E, "R6");
    repeat (16) cyc(1'b1, 1'b0, 5'h1E, 16'h0, "R6");
    cyc(1'b0, 1'b0, 5'h1E, 16'h0, "R6");
    check("R6 set", {47'h0, m_st}, 48'h1);
    repeat (3) cyc(1'b1, 1'b0, 5'h1E, 16'h0, "R6");

    // R9 gating
    check("R9 on", {47'h0, irq_o}, 48'h1);
    irq_en = 1'b0; #1;
    check("R9 off", {47'h0, irq_o}, 48'h0);
    irq_en = 1'b1; #1;

    // R7 acknowledge
    wr_reg(5'h1E, 16'hFFFE, 1'b0);
    rd(5'h1E, "R7");
    check("R7 keep", {47'h0, irq_o}, 48'h1);
    wr_reg(5'h1E, 16'h0001, 1'b0);
    rd(5'h1E, "R7");
    check("R7 clear", {47'h0, irq_o}, 48'h0);

    // R7 match and clear on the same edge
    wr_reg(5'h00, 16'h000F, 1'b0);
    cyc(1'b1, 1'b0, 5'h00, 16'h0, "");
    wr_reg(5'h1E, 16'h0001, 1'b0);
    check("R7 set wins", {47'h0, m_st}, 48'h1);
    rd(5'h1E, "R7");
    check("R7 set wins irq", {47'h0, irq_o}, 48'h1);

    // R8 zero compare disabled
    wr_reg(5'h08, 16'h0000, 1'b0);
    wr_reg(5'h00, 16'h0000, 1'b0);
    wr_reg(5'h02, 16'h0000, 1'b0);
    wr_reg(5'h04, 16'h0000, 1'b0);
    wr_reg(5'h1E, 16'h0001, 1'b0);
    repeat (4) rd(5'h1E, "R8");
    wr_reg(5'h00, 16'hFFFF, 1'b0);
    wr_reg(5'h02, 16'hFFFF, 1'b0);
    wr_reg(5'h04, 16'hFFFF, 1'b0);
    cyc(1'b1, 1'b0, 5'h1E, 16'h0, "R8");
    repeat (3) rd(5'h1E, "R8");
    check("R8 irq", {47'h0, irq_o}, 48'h0);

    // R10 unmapped
    wr_reg(5'h06, 16'hBEEF, 1'b0);
    wr_reg(5'h01, 16'hBEEF, 1'b0);
    wr_reg(5'h1C, 16'hBEEF, 1'b0);
    wr_reg(5'h09, 16'hBEEF, 1'b0);
    rd(5'h06, "R10"); rd(5'h01, "R10"); rd(5'h10, "R10"); rd(5'h1C, "R10");
    rd(5'h09, "R10");
    rd_all("R10");

    // random mix, R2 and R6 against the model
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 6) begin
        logic [4:0] a;
        case ($urandom % 8)
          0: a = 5'h00; 1: a = 5'h02; 2: a = 5'h04; 3: a = 5'h08;
          4: a = 5'h0A; 5: a = 5'h0C; 6: a = 5'h1E;
          default: a = 5'($urandom);
        endcase
        wr_reg(a, (a == 5'h08) ? 16'(m_cnt[15:0] + 16'($urandom % 40)) :
                  (a == 5'h0A || a == 5'h0C) ? 16'($urandom % 2) :
                  (a == 5'h02 || a == 5'h04) ? 16'($urandom % 2) :
                  16'($urandom), $urandom % 2 == 1);
      end else begin
        logic [4:0] a;
        a = 5'(($urandom % 8) * 2);
        if (a == 5'h0E) a = 5'h1E;
        cyc($urandom % 3 != 0, 1'b0, a, 16'h0, "R2");
      end
      if (i % 97 == 0) check("R6 irq", {47'h0, irq_o}, {47'h0, m_st & irq_en});
    end
    rd_all("R2");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule